// File: doc/BRIEF.md
# Dual-Clock Burst Capture Buffer

This block records a single fixed-length burst of converter samples on a fast sampling clock and then hands the whole burst to a slower output clock, where a serial transmitter pulls the samples out one at a time. A capture starts on a request from the sampling side. Each sample that arrives with its valid strobe is stored at the next free location, and once the burst is complete the sampling side stops writing and signals "buffer full" across the clock boundary. The output side then makes the samples available in the order they were written, one per request, and finally signals that the buffer has been drained. That release travels back to the sampling side, which can then accept the next capture request.

Storage is a two-port array with one port per clock. Each domain owns its own address counter, so no signal is driven from both clocks. The only state that crosses the boundary is a pair of toggles, one in each direction, each passed through a two-flop synchronizer and turned back into a single-cycle pulse. This is a fill-once-then-drain buffer and not a streaming FIFO: a second burst is never written while the first is still being read.

Top module: `burst_capture_buf`

## Requirements
- R1: After reset, out_valid, out_ready and out_done are low and the sampling side is idle, waiting for cap_start.
- R2: A cap_start pulse while idle opens a capture. Each cycle with smp_valid high then stores smp_data at the next address, starting from 0. Exactly DEPTH samples (100) are stored, and valid strobes after the last of them are not stored.
- R3: smp_valid strobes that arrive before a capture is opened store nothing.
- R4: When the burst is complete, the write side drops its write enable, returns its address to 0 and signals "buffer full". out_ready then rises after the two-flop synchronizer delay.
- R5: While out_ready is high, a cycle with out_req high is accepted. out_valid is high in the following out_clk cycle, and out_data then carries the next sample in write order.
- R6: out_req is ignored while out_ready is low: out_valid stays low in the following cycle.
- R7: The cycle in which the last (100th) sample is presented has out_done high and out_ready low. out_done stays high until the next burst's "buffer full" reaches the output side.
- R8: cap_start and smp_valid are ignored while a capture or a drain is in progress, so the stored burst is not disturbed.
- R9: After a drain, the "drained" handoff returns the sampling side to idle, and a new cap_start captures a fresh burst that is read back in full.
- R10: Asserting smp_rst_n and out_rst_n (active low, asynchronous assertion, synchronous release) returns each side to idle, with out_ready, out_done and out_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| smp_clk | input | 1 | Fast sampling clock |
| smp_rst_n | input | 1 | Active-low reset for the sampling domain |
| cap_start | input | 1 | Request to open a new capture |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W (12) | Sample value |
| out_clk | input | 1 | Slow output clock |
| out_rst_n | input | 1 | Active-low reset for the output domain |
| out_req | input | 1 | Request for the next stored sample |
| out_data | output | DATA_W (12) | Sample read back |
| out_valid | output | 1 | out_data holds a sample this cycle |
| out_ready | output | 1 | A full burst is available for reading |
| out_done | output | 1 | The whole burst has been read |

## Verification
The checker watches the parts of the behaviour that can be judged locally on every cycle. It confirms that the write address never passes the burst length, that a write never happens at or beyond it, and that the address steps by exactly one per write. On the output side it confirms that out_valid follows an accepted request and only an accepted request, that out_done and out_ready are never high together, and that out_done first rises together with the last valid sample. Only the bench scenarios can show that the data comes back complete and in write order, and that strobes and start requests outside a capture leave the stored burst untouched. They also show that the full/drained handoff lets a second burst replace the first.

// File: rtl/bcap_pkg.sv
package bcap_pkg;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_FILL = 2'd1,
    W_EOC  = 2'd2,
    W_HOLD = 2'd3
  } wr_state_e;

  typedef enum logic [1:0] {
    R_IDLE  = 2'd0,
    R_DRAIN = 2'd1,
    R_DONE  = 2'd2
  } rd_state_e;

endpackage

// File: rtl/bcap_rst_sync.sv
module bcap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/bcap_tog_sync.sv
module bcap_tog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_i,
  output logic pulse_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= tog_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign pulse_o = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/bcap_dpram.sv
module bcap_dpram #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 100,
  parameter int ADDR_W = 7
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/bcap_wr_ctrl.sv
module bcap_wr_ctrl
  import bcap_pkg::*;
#(
  parameter int DEPTH  = 100,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              drained_pulse_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              full_tgl_o
);

  localparam logic [ADDR_W-1:0] END_A = ADDR_W'(DEPTH);

  wr_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              tgl_q, tgl_d;
  logic              we_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    tgl_d   = tgl_q;
    we_d    = 1'b0;
    case (state_q)
      W_IDLE: begin
        if (start_i) begin
          state_d = W_FILL;
          addr_d  = '0;
        end
      end
      W_FILL: begin
        if (addr_q == END_A) begin
          state_d = W_EOC;
        end else if (valid_i) begin
          we_d   = 1'b1;
          addr_d = addr_q + 1'b1;
        end
      end
      W_EOC: begin
        addr_d  = '0;
        tgl_d   = ~tgl_q;
        state_d = W_HOLD;
      end
      W_HOLD: begin
        if (drained_pulse_i) state_d = W_IDLE;
      end
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      addr_q  <= '0;
      tgl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      tgl_q   <= tgl_d;
    end
  end

  assign we_o       = we_d;
  assign addr_o     = addr_q;
  assign full_tgl_o = tgl_q;

endmodule

// File: rtl/bcap_rd_ctrl.sv
module bcap_rd_ctrl
  import bcap_pkg::*;
#(
  parameter int DEPTH  = 100,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_pulse_i,
  input  logic              req_i,
  output logic              re_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              ready_o,
  output logic              done_o,
  output logic              drained_tgl_o
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

  rd_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              tgl_q, tgl_d;
  logic              valid_q;
  logic              re_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    tgl_d   = tgl_q;
    re_d    = 1'b0;
    case (state_q)
      R_IDLE, R_DONE: begin
        if (full_pulse_i) begin
          state_d = R_DRAIN;
          addr_d  = '0;
        end
      end
      R_DRAIN: begin
        if (req_i) begin
          re_d   = 1'b1;
          addr_d = addr_q + 1'b1;
          if (addr_q == LAST_A) begin
            state_d = R_DONE;
            addr_d  = '0;
            tgl_d   = ~tgl_q;
          end
        end
      end
      default: state_d = R_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= R_IDLE;
      addr_q  <= '0;
      tgl_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      tgl_q   <= tgl_d;
      valid_q <= re_d;
    end
  end

  assign re_o          = re_d;
  assign addr_o        = addr_q;
  assign valid_o       = valid_q;
  assign ready_o       = (state_q == R_DRAIN);
  assign done_o        = (state_q == R_DONE);
  assign drained_tgl_o = tgl_q;

endmodule

// File: rtl/burst_capture_buf.sv
module burst_capture_buf #(
  parameter int DATA_W    = 12,
  parameter int DEPTH     = 100,
  parameter int SYNC_STGS = 2
) (
  input  logic              smp_clk,
  input  logic              smp_rst_n,
  input  logic              cap_start,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              out_clk,
  input  logic              out_rst_n,
  input  logic              out_req,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_ready,
  output logic              out_done
);

  localparam int ADDR_W = $clog2(DEPTH + 1);

  logic              smp_rst_sn, out_rst_sn;
  logic              wr_we;
  logic [ADDR_W-1:0] wr_addr;
  logic              full_tgl, full_pulse;
  logic              rd_re;
  logic [ADDR_W-1:0] rd_addr;
  logic              drained_tgl, drained_pulse;

  bcap_rst_sync #(.STAGES(SYNC_STGS)) u_smp_rst (
    .clk(smp_clk), .arst_n(smp_rst_n), .rst_n_o(smp_rst_sn));

  bcap_rst_sync #(.STAGES(SYNC_STGS)) u_out_rst (
    .clk(out_clk), .arst_n(out_rst_n), .rst_n_o(out_rst_sn));

  bcap_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr (
    .clk(smp_clk), .rst_n(smp_rst_sn),
    .start_i(cap_start), .valid_i(smp_valid),
    .drained_pulse_i(drained_pulse),
    .we_o(wr_we), .addr_o(wr_addr), .full_tgl_o(full_tgl));

  bcap_tog_sync #(.STAGES(SYNC_STGS)) u_full_sync (
    .clk(out_clk), .rst_n(out_rst_sn), .tog_i(full_tgl), .pulse_o(full_pulse));

  bcap_tog_sync #(.STAGES(SYNC_STGS)) u_drained_sync (
    .clk(smp_clk), .rst_n(smp_rst_sn), .tog_i(drained_tgl), .pulse_o(drained_pulse));

  bcap_rd_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd (
    .clk(out_clk), .rst_n(out_rst_sn),
    .full_pulse_i(full_pulse), .req_i(out_req),
    .re_o(rd_re), .addr_o(rd_addr),
    .valid_o(out_valid), .ready_o(out_ready), .done_o(out_done),
    .drained_tgl_o(drained_tgl));

  bcap_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .wclk(smp_clk), .we(wr_we), .waddr(wr_addr), .wdata(smp_data),
    .rclk(out_clk), .re(rd_re), .raddr(rd_addr), .rdata(out_data));

endmodule

// File: rtl/bcap_checker.sv
module bcap_checker #(
  parameter int DEPTH  = 100,
  parameter int ADDR_W = 7
) (
  input logic              smp_clk,
  input logic              smp_rst_sn,
  input logic              wr_we,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              out_clk,
  input logic              out_rst_sn,
  input logic              out_req,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_done
);

  localparam logic [ADDR_W-1:0] END_A = ADDR_W'(DEPTH);

  a_r2_addr_bound: assert property (@(posedge smp_clk) disable iff (!smp_rst_sn)
    wr_addr <= END_A);

  a_r2_we_below_end: assert property (@(posedge smp_clk) disable iff (!smp_rst_sn)
    wr_we |-> (wr_addr < END_A));

  a_r2_addr_step: assert property (@(posedge smp_clk) disable iff (!smp_rst_sn)
    wr_we |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

  a_r5_valid_follows_req: assert property (@(posedge out_clk) disable iff (!out_rst_sn)
    (out_req && out_ready) |=> out_valid);

  a_r6_valid_needs_req: assert property (@(posedge out_clk) disable iff (!out_rst_sn)
    out_valid |-> $past(out_req && out_ready));

  a_r7_done_not_ready: assert property (@(posedge out_clk) disable iff (!out_rst_sn)
    !(out_done && out_ready));

  a_r7_done_with_last: assert property (@(posedge out_clk) disable iff (!out_rst_sn)
    $rose(out_done) |-> out_valid);

endmodule

bind burst_capture_buf bcap_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .smp_clk(smp_clk), .smp_rst_sn(smp_rst_sn), .wr_we(wr_we), .wr_addr(wr_addr),
  .out_clk(out_clk), .out_rst_sn(out_rst_sn), .out_req(out_req),
  .out_valid(out_valid), .out_ready(out_ready), .out_done(out_done));

// File: tb/burst_capture_buf_test.sv
module burst_capture_buf_test;

  localparam int DW = 12;
  localparam int N  = 100;

  logic          smp_clk = 1'b0, out_clk = 1'b0;
  logic          smp_rst_n = 1'b0, out_rst_n = 1'b0;
  logic          cap_start = 1'b0, smp_valid = 1'b0, out_req = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [DW-1:0] out_data;
  logic          out_valid, out_ready, out_done;

  int n_tests = 0, n_fail = 0, n_reads = 0;
  bit finished = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #10 smp_clk = ~smp_clk;
  always #65 out_clk = ~out_clk;

  burst_capture_buf uut (
    .smp_clk(smp_clk), .smp_rst_n(smp_rst_n), .cap_start(cap_start),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .out_clk(out_clk), .out_rst_n(out_rst_n), .out_req(out_req),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_done(out_done));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every presented sample must match the oldest expected one
  always @(negedge out_clk) begin
    if (out_valid === 1'b1 && !finished) begin
      n_reads++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected sample", int'(out_data), -1);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(out_data === e, "R5 data order", int'(out_data), int'(e));
      end
    end
  end

  task automatic pulse_start();
    @(negedge smp_clk) cap_start = 1'b1;
    @(negedge smp_clk) cap_start = 1'b0;
  endtask

  // Driver: one sample, optionally recorded as expected
  task automatic send(input logic [DW-1:0] d, input bit stored, input int gap);
    @(negedge smp_clk);
    smp_valid = 1'b1;
    smp_data  = d;
    if (stored) exp_q.push_back(d);
    @(negedge smp_clk);
    smp_valid = 1'b0;
    repeat (gap) @(negedge smp_clk);
  endtask

  task automatic wait_ready(input string tag);
    int k;
    k = 0;
    while (out_ready !== 1'b1 && k < 40) begin
      @(negedge out_clk);
      k++;
    end
    check(out_ready === 1'b1, tag, int'(out_ready), 1);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < N; i++) begin
      @(negedge out_clk) out_req = 1'b1;
      @(negedge out_clk) out_req = 1'b0;
      check(out_valid === 1'b1, "R5 valid one cycle after request", int'(out_valid), 1);
      if (i == N - 1) begin
        check(out_done === 1'b1, "R7 done with last sample", int'(out_done), 1);
        check(out_ready === 1'b0, "R7 ready low at done", int'(out_ready), 0);
      end else begin
        check(out_done === 1'b0, "R7 done early", int'(out_done), 0);
      end
      repeat (i % 2) @(negedge out_clk);
    end
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic stray_req(input string tag);
    @(negedge out_clk) out_req = 1'b1;
    @(negedge out_clk) out_req = 1'b0;
    check(out_valid === 1'b0, tag, int'(out_valid), 0);
  endtask

  initial begin
    repeat (190000) @(posedge smp_clk);
    check(1'b0, "watchdog expired", 0, 1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200;
    smp_rst_n = 1'b1;
    out_rst_n = 1'b1;
    repeat (4) @(negedge out_clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1 valid after reset", int'(out_valid), 0);
    check(out_ready === 1'b0, "R1 ready after reset", int'(out_ready), 0);
    check(out_done === 1'b0, "R1 done after reset", int'(out_done), 0);

    // R3: strobes before any start store nothing
    for (int i = 0; i < 5; i++) send(DW'(12'hF00 + i), 1'b0, 0);
    // R6: request with nothing available
    stray_req("R6 request before any burst");

    // R2: first burst, irregular gaps, start repeated mid-capture (R8)
    pulse_start();
    for (int i = 0; i < N; i++) begin
      send(DW'(i * 37 + 5), 1'b1, i % 3);
      if (i == 40) pulse_start();
    end
    // R2: strobes beyond the burst length are dropped
    for (int i = 0; i < 4; i++) send(DW'(12'hBEE + i), 1'b0, 0);

    // R4: full handoff reaches the output domain
    wait_ready("R4 ready after burst full");
    check(out_done === 1'b0, "R4 done low while ready", int'(out_done), 0);

    // R8: start and strobes while the drain is pending are ignored
    pulse_start();
    for (int i = 0; i < 20; i++) send(DW'(12'hA00 + i), 1'b0, 0);

    drain("R2 first burst fully read");
    n_reads = 0;
    stray_req("R6 request after done");
    check(out_done === 1'b1, "R7 done holds", int'(out_done), 1);

    // R9: second burst after drained handoff
    repeat (10) @(negedge smp_clk);
    pulse_start();
    for (int i = 0; i < N; i++) send(DW'(4000 - i * 29), 1'b1, (i + 1) % 2);
    repeat (2) @(negedge smp_clk);
    check(out_done === 1'b1, "R7 done holds until next full", int'(out_done), 1);
    wait_ready("R9 ready for second burst");
    check(out_done === 1'b0, "R7 done clears on new burst", int'(out_done), 0);
    drain("R9 second burst fully read");
    check(n_reads == N, "R9 read count", n_reads, N);

    // R10: reset both domains
    @(negedge smp_clk) smp_rst_n = 1'b0;
    out_rst_n = 1'b0;
    repeat (2) @(negedge out_clk);
    check(out_done === 1'b0, "R10 done cleared by reset", int'(out_done), 0);
    check(out_ready === 1'b0, "R10 ready cleared by reset", int'(out_ready), 0);
    check(out_valid === 1'b0, "R10 valid cleared by reset", int'(out_valid), 0);
    smp_rst_n = 1'b1;
    out_rst_n = 1'b1;
    repeat (4) @(negedge out_clk);
    stray_req("R10 idle after reset");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule